// File: doc/BRIEF.md
# Six-Channel Frame Serializer

This block is the transmit master of a serial sample link. A sample source raises a one-cycle load strobe once per conversion period together with six 16-bit words. The words are the voltage and current of three phases, all captured at the same instant. The block sends each set as one frame on three lines it drives itself: a serial clock, a data line and a frame-sync line. All timing comes from the master clock.

A frame begins with a frame-sync pulse one serial period wide. No serial clock runs during that pulse. Then 96 serial clock periods carry the six words, and after them the clock parks low. A rate input picks a serial clock of master/8 or master/4. An enable input releases the three output lines to high impedance.

Loaded words go first into a staging register and are copied into the transmit shifter only when a frame starts. A new load during a burst therefore waits for the next frame and never changes the frame that is being sent.

Top module: `sample_frame_tx`

## Requirements
- R1: Bus slot k occupies `samples_i[16k+15:16k]`. Slots 0..5 hold V1, I1, V2, I2, V3, I3, and a frame sends them in slot order 0 to 5, each word MSB first.
- R2: `fsync_o` is high for exactly one serial period (8 or 4 master cycles) right before the data, and `sclk_o` stays low during that pulse.
- R3: Each frame has exactly 96 rising edges of `sclk_o` after `fsync_o` falls, and no rising edge until the next frame.
- R4: Each serial period is a low half followed by a high half. `sdo_o` changes only where `sclk_o` falls and holds its value while `sclk_o` is high. The first rising edge comes half a period after `fsync_o` falls.
- R5: With `rate_fast_i` = 0 the serial period is 8 master cycles, and with 1 it is 4. The rate is sampled when a frame starts and holds for the whole frame.
- R6: While `out_en_i` = 0, `sclk_o`, `sdo_o` and `fsync_o` are high impedance. The frame logic keeps running underneath.
- R7: Outside a frame, `sclk_o`, `sdo_o` and `fsync_o` are all low, and `sdo_o` is also low during the sync pulse.
- R8: `rst_ni` low resets asynchronously. Outputs go low at once, and the pending load and any frame in flight are discarded.
- R9: A load that arrives during a burst does not change the frame in flight. Its words are sent in the frame that starts right after the current one ends.
- R10: When idle, a load sampled on master edge k raises `fsync_o` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_fast_i | input | 1 | 0: serial clock = master/8, 1: master/4 |
| out_en_i | input | 1 | 1 drives the outputs, 0 sets them to high impedance |
| load_i | input | 1 | One-cycle strobe that captures `samples_i` |
| samples_i | input | 96 | Six 16-bit words, slot k at bits 16k+15:16k |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |
| fsync_o | output | 1 | Frame sync |

## Verification
The bench deserialises the stream on serial clock rising edges and runs several word sets through the link. Distinct ascending words expose a wrong slot order. Walking-one and boundary values (0x8001, 0x7FFE) expose bit-order and shift-count errors. Solid all-ones/all-zeros words that alternate per slot expose off-by-one errors at word boundaries and a data line left high after the burst. Each set runs at both rates, so that sync width, first-edge offset and edge spacing reveal a wrong divisor. Further directed cases cover a load during a burst that also changes the rate, start latency, high impedance during a hidden frame, and a reset in the middle of a frame.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } sft_state_e;
endpackage

// File: rtl/sft_rate_timer.sv
module sft_rate_timer #(
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic fast_i,
  output logic end_o,
  output logic high_o
);
  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q, last_val, half_val;

  assign last_val = fast_i ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
  assign half_val = fast_i ? CNT_W'(DIV_FAST / 2) : CNT_W'(DIV_SLOW / 2);
  assign end_o    = (cnt_q == last_val);
  assign high_o   = (cnt_q >= half_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (end_o)     cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // divisor only changes on restart, so count never passes the wrap value
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_val);
endmodule

// File: rtl/sft_stage.sv
module sft_stage #(
  parameter int WORD_W = 16,
  parameter int N_CH   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [N_CH*WORD_W-1:0]   data_i,
  input  logic                     take_i,
  output logic [N_CH*WORD_W-1:0]   frame_o,
  output logic                     pending_o
);
  localparam int FRAME_BITS = N_CH * WORD_W;

  logic [FRAME_BITS-1:0] stage_q;
  logic                  pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      pending_q <= 1'b0;
    end else begin
      if (load_i) stage_q <= data_i;
      if (load_i)      pending_q <= 1'b1;
      else if (take_i) pending_q <= 1'b0;
    end
  end

  // slot 0 goes to the top of the send order
  for (genvar k = 0; k < N_CH; k++) begin : g_order
    assign frame_o[FRAME_BITS-1-k*WORD_W -: WORD_W] = stage_q[k*WORD_W +: WORD_W];
  end

  assign pending_o = pending_q;

  p_take_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pending_q);
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
  parameter int FRAME_BITS = 96
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  msb_o,
  output logic                  last_o
);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [BIT_W-1:0]      bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      bit_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
      bit_q <= bit_q + 1'b1;
    end
  end

  assign msb_o  = sh_q[FRAME_BITS-1];
  assign last_o = (bit_q == BIT_W'(FRAME_BITS - 1));

  p_bit_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BIT_W'(FRAME_BITS - 1));
  p_no_shift_past_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
endmodule

// File: rtl/sft_frame_ctrl.sv
module sft_frame_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic rate_fast_i,
  input  logic tmr_end_i,
  input  logic tmr_high_i,
  input  logic last_i,
  input  logic msb_i,
  output logic take_o,
  output logic fast_o,
  output logic shift_o,
  output logic idle_o,
  output logic sclk_o,
  output logic sdo_o,
  output logic fsync_o
);
  import sft_pkg::*;

  sft_state_e state_q, state_d;
  logic       fast_q;

  assign idle_o  = (state_q == ST_IDLE);
  assign take_o  = idle_o && pending_i;
  assign shift_o = (state_q == ST_DATA) && tmr_end_i && !last_i;
  assign fast_o  = fast_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take_o)               state_d = ST_SYNC;
      ST_SYNC: if (tmr_end_i)            state_d = ST_DATA;
      ST_DATA: if (tmr_end_i && last_i)  state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_o) fast_q <= rate_fast_i;
    end
  end

  assign sclk_o  = (state_q == ST_DATA) && tmr_high_i;
  assign sdo_o   = (state_q == ST_DATA) && msb_i;
  assign fsync_o = (state_q == ST_SYNC);

  p_sync_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && !tmr_end_i) |=> (state_q == ST_SYNC));
  p_sync_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && tmr_end_i) |=> (state_q == ST_DATA));
  p_no_clk_in_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> !sclk_o);
  p_sdo_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o));
  p_rate_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && $past(state_q) != ST_IDLE) |-> $stable(fast_q));
endmodule

// File: rtl/sample_frame_tx.sv
module sample_frame_tx #(
  parameter int WORD_W   = 16,
  parameter int N_CH     = 6,
  parameter int DIV_SLOW = 8,
  parameter int DIV_FAST = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rate_fast_i,
  input  logic                   out_en_i,
  input  logic                   load_i,
  input  logic [N_CH*WORD_W-1:0] samples_i,
  output logic                   sclk_o,
  output logic                   sdo_o,
  output logic                   fsync_o
);
  localparam int FRAME_BITS = N_CH * WORD_W;

  logic [FRAME_BITS-1:0] frame;
  logic pending, take, fast, shift, idle, last, msb;
  logic tmr_end, tmr_high;
  logic sclk_int, sdo_int, fsync_int;

  sft_stage #(.WORD_W(WORD_W), .N_CH(N_CH)) u_stage (
    .clk_i, .rst_ni, .load_i, .data_i(samples_i), .take_i(take),
    .frame_o(frame), .pending_o(pending)
  );

  sft_rate_timer #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_timer (
    .clk_i, .rst_ni, .restart_i(take), .fast_i(fast),
    .end_o(tmr_end), .high_o(tmr_high)
  );

  sft_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk_i, .rst_ni, .load_i(take), .shift_i(shift), .frame_i(frame),
    .msb_o(msb), .last_o(last)
  );

  sft_frame_ctrl u_ctrl (
    .clk_i, .rst_ni, .pending_i(pending), .rate_fast_i,
    .tmr_end_i(tmr_end), .tmr_high_i(tmr_high), .last_i(last), .msb_i(msb),
    .take_o(take), .fast_o(fast), .shift_o(shift), .idle_o(idle),
    .sclk_o(sclk_int), .sdo_o(sdo_int), .fsync_o(fsync_int)
  );

  assign sclk_o  = out_en_i ? sclk_int  : 1'bz;
  assign sdo_o   = out_en_i ? sdo_int   : 1'bz;
  assign fsync_o = out_en_i ? fsync_int : 1'bz;

  p_start_next_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && idle) |=> fsync_int);
  p_quiet_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && idle) |-> (sclk_o == 1'b0 && sdo_o == 1'b0 && fsync_o == 1'b0));
endmodule

// File: tb/tb_sample_frame_tx.sv
module tb_sample_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_fast = 1'b0;
  logic        out_en = 1'b1;
  logic        load = 1'b0;
  logic [95:0] samples = '0;
  wire         sclk, sdo, fsync;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sample_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .rate_fast_i(rate_fast), .out_en_i(out_en),
    .load_i(load), .samples_i(samples), .sclk_o(sclk), .sdo_o(sdo), .fsync_o(fsync)
  );

  // {rate, V1, I1, V2, I2, V3, I3}
  localparam logic [96:0] VECS [4] = '{
    {1'b0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666},
    {1'b1, 16'h8001, 16'h7FFE, 16'h00FF, 16'hFF00, 16'hA5A5, 16'h5A5A},
    {1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000},
    {1'b1, 16'h8000, 16'h4000, 16'h2000, 16'h1000, 16'h0800, 16'h0001}
  };

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] to_bus(input logic [95:0] w);
    logic [95:0] b;
    for (int k = 0; k < 6; k++) b[16*k +: 16] = w[95-16*k -: 16];
    return b;
  endfunction

  task automatic pulse_load(input logic [95:0] words);
    @(negedge clk);
    samples = to_bus(words);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic grab_frame(input int p, input logic [95:0] exp, input bit post_idle, input string tag);
    int guard = 0;
    int sync_len = 0;
    int rises = 0;
    int cyc = 0;
    int first = -1;
    int lastc = -1;
    int unstable = 0;
    bit sync_clk = 0;
    logic prev_s = 1'b0;
    logic prev_d = 1'b0;
    logic [95:0] rx = '0;
    while (fsync !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
    while (fsync === 1'b1 && guard < 3000) begin
      sync_len++;
      if (sclk !== 1'b0 || sdo !== 1'b0) sync_clk = 1;
      @(negedge clk); guard++;
    end
    chk(sync_len == p, {"R2 sync width ", tag}, 96'(sync_len), 96'(p));
    chk(!sync_clk, {"R2 clock quiet in sync ", tag}, 96'(sync_clk), 96'd0);
    while (!(rises == 96 && sclk === 1'b0) && guard < 3000) begin
      if (sclk === 1'b1 && prev_s === 1'b0) begin
        rx = {rx[94:0], sdo};
        rises++;
        if (first < 0) first = cyc;
        lastc = cyc;
      end
      if (sclk === 1'b1 && prev_s === 1'b1 && sdo !== prev_d) unstable++;
      prev_s = sclk; prev_d = sdo;
      cyc++;
      @(negedge clk); guard++;
    end
    chk(guard < 3000, {"R3 frame completes ", tag}, 96'(guard), 96'd3000);
    chk(rx == exp, {"R1 frame data ", tag}, rx, exp);
    chk(rises == 96, {"R3 edge count ", tag}, 96'(rises), 96'd96);
    chk(first == p / 2, {"R4 first edge offset ", tag}, 96'(first), 96'(p / 2));
    chk(unstable == 0, {"R4 data stable high ", tag}, 96'(unstable), 96'd0);
    chk(lastc - first == 95 * p, {"R5 period ", tag}, 96'(lastc - first), 96'(95 * p));
    chk(sdo === 1'b0 && fsync === 1'b0, {"R7 idle after burst ", tag}, {sdo, fsync}, 96'd0);
    if (post_idle) begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (sclk !== 1'b0 || sdo !== 1'b0 || fsync !== 1'b0) bad++;
      end
      chk(bad == 0, {"R7 parked low ", tag}, 96'(bad), 96'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk === 1'b0 && sdo === 1'b0 && fsync === 1'b0, "R8 reset state", {sclk, sdo, fsync}, 96'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(fsync === 1'b0 && sclk === 1'b0, "R7 no frame without load", {sclk, fsync}, 96'd0);

    // table of vectors
    for (int v = 0; v < 4; v++) begin
      rate_fast = VECS[v][96];
      pulse_load(VECS[v][95:0]);
      grab_frame(VECS[v][96] ? 4 : 8, VECS[v][95:0], 1'b1, $sformatf("vec%0d", v));
    end

    // R10: start latency
    rate_fast = 1'b0;
    pulse_load(VECS[0][95:0]);
    chk(fsync === 1'b0, "R10 one edge after load", 96'(fsync), 96'd0);
    @(negedge clk);
    chk(fsync === 1'b1, "R10 sync after second edge", 96'(fsync), 96'd1);
    repeat (900) @(negedge clk);

    // R9 + R5 latching: load during burst, rate changed mid-frame
    rate_fast = 1'b1;
    fork
      grab_frame(4, VECS[1][95:0], 1'b0, "inflight");
      begin
        pulse_load(VECS[1][95:0]);
        repeat (3) @(negedge clk);
        rate_fast = 1'b0;
        repeat (100) @(negedge clk);
        samples = to_bus(VECS[3][95:0]);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        samples = '0;
      end
    join
    grab_frame(8, VECS[3][95:0], 1'b1, "R9 queued");

    // R6: hidden frame under tri-state
    begin
      int zbad = 0;
      out_en = 1'b0;
      pulse_load(VECS[2][95:0]);
      for (int i = 0; i < 900; i++) begin
        @(negedge clk);
        if (sclk !== 1'bz || sdo !== 1'bz || fsync !== 1'bz) zbad++;
      end
      chk(zbad == 0, "R6 outputs released", 96'(zbad), 96'd0);
      out_en = 1'b1;
      @(negedge clk);
      chk(sclk === 1'b0 && sdo === 1'b0 && fsync === 1'b0, "R6 frame ran while hidden", {sclk, sdo, fsync}, 96'd0);
      pulse_load(VECS[0][95:0]);
      grab_frame(8, VECS[0][95:0], 1'b1, "R6 after enable");
    end

    // R8: reset mid-frame
    begin
      int seen = 0;
      pulse_load(VECS[2][95:0]);
      pulse_load(VECS[1][95:0]);
      repeat (200) @(negedge clk);
      #3 rst_n = 1'b0;
      #2;
      chk(sclk === 1'b0 && sdo === 1'b0 && fsync === 1'b0, "R8 async clear", {sclk, sdo, fsync}, 96'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 900; i++) begin
        @(negedge clk);
        if (fsync !== 1'b0 || sclk !== 1'b0) seen++;
      end
      chk(seen == 0, "R8 pending and frame dropped", 96'(seen), 96'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule